// File: doc/BRIEF.md
# Per-Module Clock Gate Controller

This block lets software stop and restart the clocks of eleven sub-modules in a processing subsystem. Software writes a one-bit request per module into a control word. The controller does not cut a clock the moment that bit changes. It first runs an idle handshake with the module and stops the clock only once the module has agreed. On the way back it restores the clock before it withdraws the idle request.

A second word tells software which module clocks are really running. Because of the handshake, this word can trail the control word by several cycles. A third word reports, on its own, whether each of three initiator modules is in standby. Acknowledge and standby lines arrive from other timing domains, so each passes through a two-flop synchronizer before the controller uses it.

Every module has its own small state machine, so a slow or silent module never holds up another. The physical clock cells and the gated modules are outside this block. It drives one enable line and one idle-request line per module.

Top module: `cg_clock_gate_ctrl`

## Requirements
- R1: After reset every clock enable is 1, every idle request is 0, the control word reads 0 and the status word reads 0x7FF.
- R2: The control word lives at offset 0x50, with bit i (bit 0 to bit 10) requesting a stop of module i. It is written when regWrite is high at a rising edge, and reading it returns the written bits [10:0] with bits [31:11] reading 0.
- R3: When a control bit is 1, that module's idle request rises, and its clock enable stays 1 for as long as no acknowledge has been seen.
- R4: Once the acknowledge has been taken in, the module's clock enable goes to 0 and its bit in the status word at offset 0x54 reads 0 (1 = clock running). The idle request stays high for as long as the clock is stopped.
- R5: When a stopped module's control bit returns to 0, its clock enable rises one cycle before its idle request falls.
- R6: After a wake, the status bit returns to 1 only after the module's acknowledge has gone low and passed the synchronizer.
- R7: If the control bit returns to 0 before the acknowledge arrives, the request is withdrawn, the clock enable never drops and the status bit stays 1.
- R8: Each module's handshake is independent: a module that does not acknowledge leaves the other modules' gating unaffected.
- R9: The standby word at offset 0x58 gives the synchronized standby inputs in bits [2:0], with 1 meaning standby, two rising edges after an input change. Bits [31:3] read 0.
- R10: A rising acknowledge drives the clock enable low on the third rising edge after the acknowledge changes.
- R11: Writes to any offset other than 0x50 change nothing, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (8) | Register byte offset |
| regWdata | input | DATA_W (32) | Write data |
| regRdata | output | DATA_W (32) | Read data for regAddr (combinational) |
| idleAck | input | 11 | Per-module idle acknowledge (asynchronous) |
| standbyIn | input | 3 | Initiator standby flags (asynchronous) |
| idleReq | output | 11 | Per-module idle request |
| clkEn | output | 11 | Per-module clock enable |

## Verification
The hardest state to reach from the ports is a withdrawal caught inside the request window. The stop bit has to be cleared after the request is visible but before any acknowledge reaches the state machine. The bench holds the acknowledge low, writes the stop bit and then clears it two cycles later. It watches the clock enable on every cycle in between. The wake ordering is checked cycle by cycle, with the acknowledge held high so that the one-cycle overlap of clock enable and request can be seen before the status bit moves.

// File: rtl/cg_pkg.sv
package cg_pkg;

  localparam int unsigned CG_NUM_MOD  = 11;
  localparam int unsigned CG_NUM_INIT = 3;

  localparam logic [7:0] CG_OFS_CTRL    = 8'h50;
  localparam logic [7:0] CG_OFS_STATUS  = 8'h54;
  localparam logic [7:0] CG_OFS_STANDBY = 8'h58;

  typedef enum logic [1:0] {
    HS_RUN      = 2'd0,
    HS_REQ_IDLE = 2'd1,
    HS_IDLE     = 2'd2,
    HS_WAKE     = 2'd3
  } hsState_t;

  // Per-module strobes from the handshake machines back to the datapath
  typedef struct packed {
    logic [CG_NUM_MOD-1:0] gateOn;   // clock enable
    logic [CG_NUM_MOD-1:0] reqOut;   // idle request
    logic [CG_NUM_MOD-1:0] clkRun;   // status: clock known to be running
  } gateStrobe_t;

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= '0;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/cg_hs_fsm.sv
module cg_hs_fsm
  import cg_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic stopReq,
  input  logic ackSync,
  output logic clkEn,
  output logic idleReq,
  output logic clkRunning
);

  hsState_t state, stateNext;
  logic     wakeFirst;

  always_comb begin
    stateNext = state;
    unique case (state)
      HS_RUN:      if (stopReq) stateNext = HS_REQ_IDLE;
      HS_REQ_IDLE: begin
        if (!stopReq)     stateNext = HS_RUN;
        else if (ackSync) stateNext = HS_IDLE;
      end
      HS_IDLE:     if (!stopReq) stateNext = HS_WAKE;
      HS_WAKE:     if (!wakeFirst && !ackSync) stateNext = HS_RUN;
      default:     stateNext = HS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= HS_RUN;
      wakeFirst <= 1'b0;
    end else begin
      state     <= stateNext;
      wakeFirst <= (state == HS_IDLE) && !stopReq;
    end
  end

  assign clkEn      = (state != HS_IDLE);
  assign idleReq    = (state == HS_REQ_IDLE) || (state == HS_IDLE) ||
                      ((state == HS_WAKE) && wakeFirst);
  assign clkRunning = (state == HS_RUN) || (state == HS_REQ_IDLE);

  // R3: the clock only stops after an acknowledge seen while a stop was requested
  assert_stop_after_ack_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clkEn) |-> ($past(ackSync) && $past(stopReq)));

  // R4: a stopped clock always has its idle request held
  assert_gated_holds_req_R4: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |-> idleReq);

  // R5: the request never drops while the clock is still stopped
  assert_wake_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(idleReq) |-> clkEn);

  // R6: running status returns only once the acknowledge is low
  assert_status_after_ackdrop_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkRunning) |-> !$past(ackSync));

  // R7: a running status always means an enabled clock
  assert_run_has_clock_R7: assert property (@(posedge clk) disable iff (!rstN)
    clkRunning |-> clkEn);

endmodule

// File: rtl/cg_ctrl.sv
module cg_ctrl
  import cg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CG_NUM_MOD-1:0] stopBits,
  input  logic [CG_NUM_MOD-1:0] ackSync,
  output gateStrobe_t           strobes
);

  for (genvar m = 0; m < CG_NUM_MOD; m++) begin : g_mod
    cg_hs_fsm u_fsm (
      .clk        (clk),
      .rstN       (rstN),
      .stopReq    (stopBits[m]),
      .ackSync    (ackSync[m]),
      .clkEn      (strobes.gateOn[m]),
      .idleReq    (strobes.reqOut[m]),
      .clkRunning (strobes.clkRun[m])
    );
  end

endmodule

// File: rtl/cg_regs.sv
module cg_regs
  import cg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrite,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [DATA_W-1:0]      regWdata,
  output logic [DATA_W-1:0]      regRdata,
  input  logic [CG_NUM_MOD-1:0]  idleAck,
  input  logic [CG_NUM_INIT-1:0] standbyIn,
  input  gateStrobe_t            strobes,
  output logic [CG_NUM_MOD-1:0]  stopBits,
  output logic [CG_NUM_MOD-1:0]  ackSync
);

  localparam logic [ADDR_W-1:0] OfsCtrl    = ADDR_W'(CG_OFS_CTRL);
  localparam logic [ADDR_W-1:0] OfsStatus  = ADDR_W'(CG_OFS_STATUS);
  localparam logic [ADDR_W-1:0] OfsStandby = ADDR_W'(CG_OFS_STANDBY);

  logic [CG_NUM_MOD-1:0]  ctrlReg;
  logic [CG_NUM_INIT-1:0] standbySync;
  logic                   unusedWdataHi;

  assign unusedWdataHi = ^regWdata[DATA_W-1:CG_NUM_MOD];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              ctrlReg <= '0;
    else if (regWrite && regAddr == OfsCtrl) ctrlReg <= regWdata[CG_NUM_MOD-1:0];
  end

  cg_sync #(.WIDTH(CG_NUM_MOD), .STAGES(2)) u_ackSync (
    .clk(clk), .rstN(rstN), .din(idleAck), .dout(ackSync)
  );

  cg_sync #(.WIDTH(CG_NUM_INIT), .STAGES(2)) u_sbySync (
    .clk(clk), .rstN(rstN), .din(standbyIn), .dout(standbySync)
  );

  always_comb begin
    regRdata = '0;
    if (regAddr == OfsCtrl)         regRdata[CG_NUM_MOD-1:0]  = ctrlReg;
    else if (regAddr == OfsStatus)  regRdata[CG_NUM_MOD-1:0]  = strobes.clkRun;
    else if (regAddr == OfsStandby) regRdata[CG_NUM_INIT-1:0] = standbySync;
  end

  assign stopBits = ctrlReg;

  // R2: bits above the module field never read as 1
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[DATA_W-1:CG_NUM_MOD] == '0);

  // R11: the control word only moves on a write to its own offset
  assert_ctrl_write_only_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$past(regWrite && regAddr == OfsCtrl) |-> $stable(ctrlReg));

endmodule

// File: rtl/cg_clock_gate_ctrl.sv
module cg_clock_gate_ctrl
  import cg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrite,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [DATA_W-1:0]      regWdata,
  output logic [DATA_W-1:0]      regRdata,
  input  logic [CG_NUM_MOD-1:0]  idleAck,
  input  logic [CG_NUM_INIT-1:0] standbyIn,
  output logic [CG_NUM_MOD-1:0]  idleReq,
  output logic [CG_NUM_MOD-1:0]  clkEn
);

  gateStrobe_t           strobes;
  logic [CG_NUM_MOD-1:0] stopBits;
  logic [CG_NUM_MOD-1:0] ackSync;

  cg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .regWrite  (regWrite),
    .regAddr   (regAddr),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .idleAck   (idleAck),
    .standbyIn (standbyIn),
    .strobes   (strobes),
    .stopBits  (stopBits),
    .ackSync   (ackSync)
  );

  cg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stopBits (stopBits),
    .ackSync  (ackSync),
    .strobes  (strobes)
  );

  assign idleReq = strobes.reqOut;
  assign clkEn   = strobes.gateOn;

endmodule

// File: tb/sim_cg_clock_gate_ctrl.sv
module sim_cg_clock_gate_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [10:0] idleAck = '0;
  logic [2:0]  standbyIn = '0;
  logic [10:0] idleReq;
  logic [10:0] clkEn;

  int nVec = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cg_clock_gate_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .idleAck(idleAck),
    .standbyIn(standbyIn), .idleReq(idleReq), .clkEn(clkEn)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWr(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWrite = 1'b1;
    @(negedge clk);
    regWrite = 1'b0; regWdata = '0;
  endtask

  task automatic regRd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1", "clkEn", 32'(clkEn), 32'h7FF);
    check("R1", "idleReq", 32'(idleReq), 32'h0);
    regRd(8'h50, d); check("R1", "ctrl", d, 32'h0);
    regRd(8'h54, d); check("R1", "status", d, 32'h7FF);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    regWr(8'h50, 32'hFFFF_F800);
    regRd(8'h50, d); check("R2", "upper bits only", d, 32'h0);
    regWr(8'h54, 32'h0000_07FF);
    regWr(8'h10, 32'h0000_07FF);
    step(4);
    regRd(8'h50, d); check("R11", "ctrl after stray writes", d, 32'h0);
    check("R11", "idleReq after stray writes", 32'(idleReq), 32'h0);
    check("R11", "clkEn after stray writes", 32'(clkEn), 32'h7FF);
    regRd(8'h10, d); check("R11", "unmapped read", d, 32'h0);
  endtask

  task automatic t_gate;
    logic [31:0] d;
    regWr(8'h50, 32'h010);
    regRd(8'h50, d); check("R2", "ctrl readback", d, 32'h010);
    step(1);
    check("R3", "request raised", 32'(idleReq), 32'h010);
    step(5);
    check("R3", "clock held without ack", 32'(clkEn), 32'h7FF);
    regRd(8'h54, d); check("R3", "status before ack", d, 32'h7FF);
    idleAck[4] = 1'b1;
    step(1); check("R10", "clkEn after 1 edge", 32'(clkEn), 32'h7FF);
    step(1); check("R10", "clkEn after 2 edges", 32'(clkEn), 32'h7FF);
    step(1); check("R10", "clkEn after 3 edges", 32'(clkEn), 32'h7EF);
    regRd(8'h54, d); check("R4", "status gated", d, 32'h7EF);
    step(3);
    check("R4", "request held while gated", 32'(idleReq), 32'h010);
  endtask

  task automatic t_wake;
    logic [31:0] d;
    regWr(8'h50, 32'h0);
    step(1);
    check("R5", "clkEn up first", 32'(clkEn), 32'h7FF);
    check("R5", "request still up", 32'(idleReq), 32'h010);
    step(1);
    check("R5", "request dropped next", 32'(idleReq), 32'h0);
    step(4);
    regRd(8'h54, d); check("R6", "status while ack high", d, 32'h7EF);
    idleAck[4] = 1'b0;
    step(2);
    regRd(8'h54, d); check("R6", "status after 2 edges", d, 32'h7EF);
    step(1);
    regRd(8'h54, d); check("R6", "status after 3 edges", d, 32'h7FF);
  endtask

  task automatic t_withdraw;
    logic [31:0] d;
    logic [10:0] minEn;
    minEn = 11'h7FF;
    regWr(8'h50, 32'h001);
    minEn &= clkEn;
    step(1);
    check("R7", "request visible", 32'(idleReq), 32'h001);
    minEn &= clkEn;
    step(1); minEn &= clkEn;
    regWr(8'h50, 32'h0); minEn &= clkEn;
    step(1); minEn &= clkEn;
    check("R7", "request withdrawn", 32'(idleReq), 32'h0);
    for (int i = 0; i < 5; i++) begin step(1); minEn &= clkEn; end
    check("R7", "clock never stopped", 32'(minEn), 32'h7FF);
    regRd(8'h54, d); check("R7", "status kept", d, 32'h7FF);
  endtask

  task automatic t_indep;
    logic [31:0] d;
    regWr(8'h50, 32'h401);
    idleAck[10] = 1'b1;
    step(6);
    check("R8", "only acked module gated", 32'(clkEn), 32'h3FF);
    check("R8", "both requests up", 32'(idleReq), 32'h401);
    regRd(8'h54, d); check("R8", "status partial", d, 32'h3FF);
    idleAck[0] = 1'b1;
    step(4);
    check("R8", "second module gated", 32'(clkEn), 32'h3FE);
    regWr(8'h50, 32'h0);
    step(2);
    idleAck = '0;
    step(5);
    check("R8", "all clocks back", 32'(clkEn), 32'h7FF);
    check("R8", "no requests", 32'(idleReq), 32'h0);
    regRd(8'h54, d); check("R8", "status restored", d, 32'h7FF);
  endtask

  task automatic t_standby;
    logic [31:0] d;
    standbyIn = 3'b101;
    step(1);
    regRd(8'h58, d); check("R9", "standby after 1 edge", d, 32'h0);
    step(1);
    regRd(8'h58, d); check("R9", "standby after 2 edges", d, 32'h5);
    standbyIn = 3'b111;
    step(2);
    regRd(8'h58, d); check("R9", "standby all set", d, 32'h7);
    regRd(8'h54, d); check("R9", "status independent", d, 32'h7FF);
  endtask

  logic done = 1'b0;

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    t_reset();
    t_regs();
    t_gate();
    t_wake();
    t_withdraw();
    t_indep();
    t_standby();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nVec++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

endmodule